// File: doc/BRIEF.md
# Bus Phase Mismatch Handler

This block decides what a script engine does when a block-move finds the bus in a phase other than the one the script expected. A single-cycle mismatch strobe arrives with two more inputs: the direction of the interrupted transfer and the phase the bus has moved to. The block then takes one of two paths. It can send the script program counter to one of two programmable jump addresses, so that recovery code runs without software. Or it can post a phase-mismatch status event and halt the script, so that software handles the mismatch.

Software sets up the block with byte writes. Four registers can be written: two 32-bit jump-address registers, a control byte that holds the jump-enable bit and the override bit, and a phase status byte. The low three bits of the status byte always follow the latest bus phase. The upper five bits belong to software and a mismatch leaves them unchanged. All results are registered and appear in the cycle after the strobe.

Top module: `pmm_handler`

## Requirements
- R1: After reset, both jump addresses, the control byte and the phase status byte are zero, and `pc_load`, `halt` and `evt_byte` are low.
- R2: The phase sits in bits [2:0] of `phase_status`. The encoding is data-out 0, data-in 1, command 2, status 3, message-out 6, message-in 7. One cycle after a strobe, bits [2:0] equal the strobe's `mm_phase`, on both the jump path and the halt path.
- R3: A strobe leaves `phase_status[7:3]` unchanged. A software write to the status register (`wr_sel`=3) loads all eight bits.
- R4: If control bit 7 (jump enable) is set when the strobe arrives, and either control bit 6 (override) is set or `mm_outbound` is 1, then one cycle later `pc_load` pulses with `pc_value` equal to jump address 1.
- R5: If jump enable is set, override is clear and `mm_outbound` is 0, then one cycle later `pc_load` pulses with `pc_value` equal to jump address 2.
- R6: If jump enable is clear, then one cycle after the strobe `evt_byte` equals 8'h80 (phase-mismatch event in bit 7) and `halt` pulses, while `pc_load` stays low.
- R7: `pc_load` and the event/halt pair never pulse in the same cycle. Each lasts one cycle, and neither appears without a strobe in the cycle before.
- R8: Jump address 1 is written with `wr_sel`=0 and jump address 2 with `wr_sel`=1. `wr_lane` n writes bits [8n+7:8n] and leaves the other bytes unchanged.
- R9: The decision uses the register values from before the strobe edge, so a control write in the strobe cycle does not change that decision. When a status write and a strobe happen in the same cycle, bits [7:3] take the written data and bits [2:0] take the new phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_sel | input | 2 | Register select: 0 jump address 1, 1 jump address 2, 2 control, 3 phase status |
| wr_lane | input | 2 | Byte lane within a jump address register |
| wr_data | input | 8 | Write data byte |
| mm_strobe | input | 1 | Phase mismatch detected |
| mm_outbound | input | 1 | 1 if the interrupted transfer was outbound |
| mm_phase | input | 3 | New bus phase |
| pc_load | output | 1 | Program-counter load pulse |
| pc_value | output | 32 | Program-counter value, valid with `pc_load` |
| evt_byte | output | 8 | SCSI status event bits, bit 7 = phase mismatch |
| halt | output | 1 | Script halt pulse |
| phase_status | output | 8 | Phase status byte |

## Verification
Every output of the block is due exactly one clock edge after the edge that samples the strobe or write. This includes the load pulse with its value, the event byte, the halt pulse and the new phase bits. The bench drives inputs at the falling edge and holds each strobe for exactly one rising edge. It samples at the next falling edge, which is where these results must appear. One falling edge later it samples again and requires every pulse to be low, which shows that each pulse lasts a single cycle.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int ADDR_W = 32;
  localparam int LANES  = ADDR_W / 8;
  localparam int PH_W   = 3;

  typedef enum logic [PH_W-1:0] {
    PH_DATA_OUT = 3'd0,
    PH_DATA_IN  = 3'd1,
    PH_COMMAND  = 3'd2,
    PH_STATUS   = 3'd3,
    PH_MSG_OUT  = 3'd6,
    PH_MSG_IN   = 3'd7
  } bus_phase_e;

  typedef enum logic [1:0] {
    SEL_JUMP1  = 2'd0,
    SEL_JUMP2  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_OVR_BIT = 6;
  localparam int EVT_MM_BIT   = 7;
endpackage

// File: rtl/pmm_regs.sv
module pmm_regs
  import pmm_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [1:0]    wr_lane,
  input  logic [7:0]    wr_data,
  input  logic          mm_strobe,
  input  logic [PH_W-1:0] mm_phase,
  output logic [AW-1:0] jump1,
  output logic [AW-1:0] jump2,
  output logic [7:0]    ctrl,
  output logic [7:0]    status
);
  localparam int NL = AW / 8;

  logic wr_j1, wr_j2, wr_ctl, wr_st;
  assign wr_j1  = wr_en && (wr_sel == SEL_JUMP1);
  assign wr_j2  = wr_en && (wr_sel == SEL_JUMP2);
  assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_st  = wr_en && (wr_sel == SEL_STATUS);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        jump1[8*g +: 8] <= '0;
        jump2[8*g +: 8] <= '0;
      end else begin
        if (wr_j1 && (32'(wr_lane) == g)) jump1[8*g +: 8] <= wr_data;
        if (wr_j2 && (32'(wr_lane) == g)) jump2[8*g +: 8] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_ctl) ctrl <= wr_data;
  end

  logic [7:PH_W] upper_nxt;
  assign upper_nxt = wr_st ? wr_data[7:PH_W] : status[7:PH_W];

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else if (mm_strobe) status <= {upper_nxt, mm_phase};
    else if (wr_st) status <= wr_data;
  end

  // R2: the phase field follows the strobe one cycle later
  assert_phase_follows_R2: assert property (@(posedge clk) disable iff (rst)
    $past(mm_strobe) |-> status[PH_W-1:0] == $past(mm_phase));
  // R3: without a status write, a strobe keeps the upper bits
  assert_upper_kept_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(mm_strobe) && !$past(wr_st)) |-> status[7:PH_W] == $past(status[7:PH_W]));
endmodule

// File: rtl/pmm_decide.sv
module pmm_decide
  import pmm_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mm_strobe,
  input  logic          mm_outbound,
  input  logic          jump_en,
  input  logic          jump_ovr,
  input  logic [AW-1:0] jump1,
  input  logic [AW-1:0] jump2,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic [7:0]    evt_byte,
  output logic          halt
);
  logic use_first;
  assign use_first = jump_ovr || mm_outbound;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load  <= 1'b0;
      pc_value <= '0;
      evt_byte <= '0;
      halt     <= 1'b0;
    end else begin
      pc_load  <= mm_strobe && jump_en;
      evt_byte <= '0;
      halt     <= mm_strobe && !jump_en;
      if (mm_strobe && jump_en) pc_value <= use_first ? jump1 : jump2;
      if (mm_strobe && !jump_en) evt_byte[EVT_MM_BIT] <= 1'b1;
    end
  end

  // R7: load and event never together, and only after a strobe
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(pc_load && (halt || evt_byte[EVT_MM_BIT])));
  assert_load_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_load || halt) |-> $past(mm_strobe));
  // R6: halt comes with the mismatch event, only when jumping was disabled
  assert_halt_event_R6: assert property (@(posedge clk) disable iff (rst)
    halt |-> (evt_byte[EVT_MM_BIT] && !$past(jump_en)));
  // R4: override or outbound picks the first address
  assert_first_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_load && $past(jump_ovr || mm_outbound)) |-> pc_value == $past(jump1));
  // R5: inbound without override picks the second address
  assert_second_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !$past(jump_ovr || mm_outbound)) |-> pc_value == $past(jump2));
endmodule

// File: rtl/pmm_handler.sv
module pmm_handler
  import pmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [1:0]        wr_lane,
  input  logic [7:0]        wr_data,
  input  logic              mm_strobe,
  input  logic              mm_outbound,
  input  logic [PH_W-1:0]   mm_phase,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic [7:0]        evt_byte,
  output logic              halt,
  output logic [7:0]        phase_status
);
  logic [ADDR_W-1:0] jump1, jump2;
  logic [7:0]        ctrl;

  pmm_regs #(.AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_lane(wr_lane), .wr_data(wr_data),
    .mm_strobe(mm_strobe), .mm_phase(mm_phase),
    .jump1(jump1), .jump2(jump2), .ctrl(ctrl), .status(phase_status)
  );

  pmm_decide #(.AW(ADDR_W)) u_decide (
    .clk(clk), .rst(rst),
    .mm_strobe(mm_strobe), .mm_outbound(mm_outbound),
    .jump_en(ctrl[CTRL_EN_BIT]), .jump_ovr(ctrl[CTRL_OVR_BIT]),
    .jump1(jump1), .jump2(jump2),
    .pc_load(pc_load), .pc_value(pc_value), .evt_byte(evt_byte), .halt(halt)
  );

  logic [5:0] ctrl_unused;
  assign ctrl_unused = ctrl[5:0];
endmodule

// File: tb/sim_pmm_handler.sv
module sim_pmm_handler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [1:0]  wr_lane = '0;
  logic [7:0]  wr_data = '0;
  logic        mm_strobe = 1'b0;
  logic        mm_outbound = 1'b0;
  logic [2:0]  mm_phase = '0;
  logic        pc_load;
  logic [31:0] pc_value;
  logic [7:0]  evt_byte;
  logic        halt;
  logic [7:0]  phase_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmm_handler u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_lane(wr_lane),
    .wr_data(wr_data), .mm_strobe(mm_strobe), .mm_outbound(mm_outbound),
    .mm_phase(mm_phase), .pc_load(pc_load), .pc_value(pc_value),
    .evt_byte(evt_byte), .halt(halt), .phase_status(phase_status)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] lane, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_lane = lane; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic [1:0] sel, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(sel, 2'(i), v[8*i +: 8]);
  endtask

  // strobe for one edge, optionally with a coincident write; returns at the result cycle
  task automatic strobe(input logic outb, input logic [2:0] ph, input logic co_wr,
                        input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    mm_strobe = 1'b1; mm_outbound = outb; mm_phase = ph;
    wr_en = co_wr; wr_sel = sel; wr_lane = 2'd0; wr_data = d;
    @(negedge clk);
    mm_strobe = 1'b0; wr_en = 1'b0;
  endtask

  task automatic expect_jump(input string req, input logic [31:0] addr, input logic [2:0] ph);
    chk(req, "pc_load", 32'(pc_load), 32'd1);
    chk(req, "pc_value", pc_value, addr);
    chk(req, "evt_byte", 32'(evt_byte), 32'h0);
    chk(req, "halt", 32'(halt), 32'd0);
    chk("R2", "phase bits", 32'(phase_status[2:0]), 32'(ph));
    @(negedge clk);
    chk("R7", "pc_load one cycle", 32'(pc_load), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "status", 32'(phase_status), 32'h0);
    chk("R1", "pc_load", 32'(pc_load), 32'd0);
    chk("R1", "halt", 32'(halt), 32'd0);
    chk("R1", "evt_byte", 32'(evt_byte), 32'h0);
    wr(2'd2, 2'd0, 8'h80);
    strobe(1'b1, 3'd0, 1'b0, 2'd0, 8'h0);
    expect_jump("R1", 32'h0, 3'd0);
    strobe(1'b0, 3'd0, 1'b0, 2'd0, 8'h0);
    expect_jump("R1", 32'h0, 3'd0);
  endtask

  task automatic t_jump_paths;
    wr_word(2'd0, 32'h11223344);
    wr_word(2'd1, 32'hA5A55A5A);
    wr(2'd2, 2'd0, 8'h80);
    strobe(1'b1, 3'd1, 1'b0, 2'd0, 8'h0);
    expect_jump("R4", 32'h11223344, 3'd1);
    strobe(1'b0, 3'd7, 1'b0, 2'd0, 8'h0);
    expect_jump("R5", 32'hA5A55A5A, 3'd7);
    wr(2'd2, 2'd0, 8'hC0);
    strobe(1'b0, 3'd2, 1'b0, 2'd0, 8'h0);
    expect_jump("R4", 32'h11223344, 3'd2);
  endtask

  task automatic t_halt_path;
    wr(2'd2, 2'd0, 8'h40);
    strobe(1'b1, 3'd6, 1'b0, 2'd0, 8'h0);
    chk("R6", "evt_byte", 32'(evt_byte), 32'h80);
    chk("R6", "halt", 32'(halt), 32'd1);
    chk("R6", "pc_load", 32'(pc_load), 32'd0);
    chk("R2", "phase on halt path", 32'(phase_status[2:0]), 32'd6);
    @(negedge clk);
    chk("R7", "halt one cycle", 32'(halt), 32'd0);
    chk("R7", "evt one cycle", 32'(evt_byte), 32'h0);
  endtask

  task automatic t_upper_bits;
    wr(2'd3, 2'd0, 8'hA8);
    chk("R3", "status write", 32'(phase_status), 32'hA8);
    strobe(1'b0, 3'd3, 1'b0, 2'd0, 8'h0);
    chk("R3", "upper kept", 32'(phase_status), 32'hAB);
    @(negedge clk);
    chk("R6", "halt path again", 32'(halt), 32'd0);
  endtask

  task automatic t_lane_write;
    wr(2'd0, 2'd2, 8'hEE);
    wr(2'd2, 2'd0, 8'h80);
    strobe(1'b1, 3'd0, 1'b0, 2'd0, 8'h0);
    expect_jump("R8", 32'h11EE3344, 3'd0);
    wr(2'd1, 2'd0, 8'h01);
    strobe(1'b0, 3'd1, 1'b0, 2'd0, 8'h0);
    expect_jump("R8", 32'hA5A55A01, 3'd1);
  endtask

  task automatic t_coincident;
    strobe(1'b0, 3'd6, 1'b1, 2'd3, 8'hF0);
    chk("R9", "status merge", 32'(phase_status), 32'hF6);
    @(negedge clk);
    strobe(1'b1, 3'd2, 1'b1, 2'd2, 8'h00);
    chk("R9", "old ctrl used: pc_load", 32'(pc_load), 32'd1);
    chk("R9", "old ctrl used: halt", 32'(halt), 32'd0);
    @(negedge clk);
    strobe(1'b1, 3'd7, 1'b0, 2'd0, 8'h0);
    chk("R9", "new ctrl later: halt", 32'(halt), 32'd1);
    chk("R9", "new ctrl later: pc_load", 32'(pc_load), 32'd0);
  endtask

  initial begin
    t_reset();
    t_jump_paths();
    t_halt_path();
    t_upper_bits();
    t_lane_write();
    t_coincident();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule